// File: doc/BRIEF.md
# Aligned Selectable Clock Divider

This block turns one fast input clock into two slower clocks. Channel A runs at one half or one quarter of the input rate. Channel B runs at one quarter or one sixth of the input rate. Each channel has its own select pin. Both channels are decoded from a single shared count of input cycles that wraps every twelve cycles, called a frame. Because of this, their common rising edges fall in the same input cycle from any starting state. Each output has a 50% duty cycle.

The run enable is captured on the falling input edge. It starts or stops the count only at a frame boundary, which is the point where both outputs are low and about to rise together. A stop therefore lets the current frame finish, and neither output ever shows a shortened pulse. A select change is also held back until the next frame boundary. An asynchronous master reset clears the whole state. After reset, every instance that shares the clock and the reset starts its first frame on the same input edge.

Top module: `aligned_clk_divider`

## Requirements
- R1: With `selDivA4`=0, `clkOutA` has a period of 2 input cycles (1 high, 1 low). With `selDivA4`=1, the period is 4 cycles (2 high, 2 low).
- R2: With `selDivB6`=0, `clkOutB` has a period of 4 input cycles (2 high, 2 low). With `selDivB6`=1, the period is 6 cycles (3 high, 3 low).
- R3: Both outputs rise in the same input cycle at the start of every frame. Whenever the ratio of B is a multiple of the ratio of A, every rising edge of `clkOutB` coincides with a rising edge of `clkOutA`.
- R4: `runEnable` is sampled only on the falling edge of `clkIn`. A level present only between two falling edges has no effect.
- R5: The run state changes only at a frame boundary. After a stop, the outputs keep toggling until the 12-cycle frame completes. From idle, the outputs go high on the first rising edge after the falling edge that captured a 1.
- R6: While idle, both outputs are low and the count is held at the frame start. On resume, both outputs rise together.
- R7: `masterRst` is asynchronous and active high. It drives both outputs low at once, without waiting for a clock edge. After release, the first rising edges of the two outputs fall in the same input cycle.
- R8: A change on `selDivA4` or `selDivB6` takes effect only at a frame boundary. The selects are sampled on the rising edge that starts a frame.
- R9: No high or low interval on either output is shorter than half the nominal period of the ratio in force. Across a ratio switch, the shorter of the two half periods applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Fast input clock |
| masterRst | input | 1 | Asynchronous active-high reset of all divider state |
| runEnable | input | 1 | Run request, captured on the falling edge of `clkIn` |
| selDivA4 | input | 1 | Channel A ratio: 0 selects divide by 2, 1 selects divide by 4 |
| selDivB6 | input | 1 | Channel B ratio: 0 selects divide by 4, 1 selects divide by 6 |
| clkOutA | output | 1 | Divided clock A |
| clkOutB | output | 1 | Divided clock B |

## Verification
The assertions take four things for granted:
- `masterRst` stays high across at least one rising edge of `clkIn`.
- The selects settle between rising edges.
- `runEnable` settles between falling edges.
- The configured ratios are even and divide the frame length.

The stimulus follows these rules. It changes selects and enable in the low half of the input clock, or in windows chosen on purpose to straddle only a rising edge. It holds reset for at least two rising edges. It keeps the default ratios. Each output is compared every cycle against a reference divider. Pulse widths are also tracked, to catch any runt interval.

// File: rtl/acd_pkg.sv
`timescale 1ns/1ps
package acd_pkg;

  // Strobes the control half hands to the counting datapath each cycle.
  typedef struct packed {
    logic advance;  // count moves on and outputs follow the decode
    logic useHiA;   // channel A uses its larger ratio
    logic useHiB;   // channel B uses its larger ratio
  } divStrobe_t;

  function automatic int gcdOf(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcmOf(input int a, input int b);
    return (a / gcdOf(a, b)) * b;
  endfunction

endpackage

// File: rtl/acd_ctrl.sv
`timescale 1ns/1ps
module acd_ctrl
  import acd_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstIn,
  input  logic       runEnable,
  input  logic       selDivA4,
  input  logic       selDivB6,
  input  logic       atZero,
  output divStrobe_t strobe
);

  // Enable capture on the falling input edge (R4).
  logic enFall;
  always_ff @(negedge clkIn or posedge rstIn) begin
    if (rstIn) enFall <= 1'b0;
    else       enFall <= runEnable;
  end

  // Run state and select latches move only at the frame boundary (R5, R8).
  logic runQ;
  logic hiAQ;
  logic hiBQ;
  always_ff @(posedge clkIn or posedge rstIn) begin
    if (rstIn) begin
      runQ <= 1'b0;
      hiAQ <= 1'b0;
      hiBQ <= 1'b0;
    end else if (atZero) begin
      runQ <= enFall;
      hiAQ <= selDivA4;
      hiBQ <= selDivB6;
    end
  end

  always_comb begin
    strobe.advance = atZero ? enFall   : runQ;
    strobe.useHiA  = atZero ? selDivA4 : hiAQ;
    strobe.useHiB  = atZero ? selDivB6 : hiBQ;
  end

  a_r5_run_at_zero: assert property (@(posedge clkIn) disable iff (rstIn)
    (runQ != $past(runQ)) |-> $past(atZero));

  a_r8_sel_at_zero: assert property (@(posedge clkIn) disable iff (rstIn)
    ((hiAQ != $past(hiAQ)) || (hiBQ != $past(hiBQ))) |-> $past(atZero));

endmodule

// File: rtl/acd_path.sv
`timescale 1ns/1ps
module acd_path
  import acd_pkg::*;
#(
  parameter int A_LO   = 2,
  parameter int A_HI   = 4,
  parameter int B_LO   = 4,
  parameter int B_HI   = 6,
  parameter int PERIOD = 12,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic       clkIn,
  input  logic       rstIn,
  input  divStrobe_t strobe,
  output logic       atZero,
  output logic       clkOutA,
  output logic       clkOutB
);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       outQ;

  assign atZero = (cnt == '0);

  // Shared frame counter; wraps at PERIOD, holds while not advancing.
  always_ff @(posedge clkIn or posedge rstIn) begin
    if (rstIn)                  cnt <= '0;
    else if (strobe.advance) begin
      if (cnt == CNT_W'(PERIOD - 1)) cnt <= '0;
      else                           cnt <= cnt + 1'b1;
    end
  end

  // One decode per channel: high for the first half of each ratio period.
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam int RLO = (ch == 0) ? A_LO : B_LO;
    localparam int RHI = (ch == 0) ? A_HI : B_HI;
    logic hiSel;
    logic lvlLo;
    logic lvlHi;
    logic chOut;
    assign hiSel = (ch == 0) ? strobe.useHiA : strobe.useHiB;
    assign lvlLo = ((int'(cnt) % RLO) * 2) < RLO;
    assign lvlHi = ((int'(cnt) % RHI) * 2) < RHI;
    always_ff @(posedge clkIn or posedge rstIn) begin
      if (rstIn)               chOut <= 1'b0;
      else if (strobe.advance) chOut <= hiSel ? lvlHi : lvlLo;
      else                     chOut <= 1'b0;
    end
    assign outQ[ch] = chOut;
  end

  assign clkOutA = outQ[0];
  assign clkOutB = outQ[1];

  a_r6_idle_low: assert property (@(posedge clkIn) disable iff (rstIn)
    !strobe.advance |=> (outQ == 2'b00));

  a_r3_common_rise: assert property (@(posedge clkIn) disable iff (rstIn)
    ($rose(outQ[1]) &&
     ((($past(strobe.useHiB) ? B_HI : B_LO) % ($past(strobe.useHiA) ? A_HI : A_LO)) == 0))
    |-> $rose(outQ[0]));

endmodule

// File: rtl/aligned_clk_divider.sv
`timescale 1ns/1ps
module aligned_clk_divider
  import acd_pkg::*;
#(
  parameter int A_LO = 2,
  parameter int A_HI = 4,
  parameter int B_LO = 4,
  parameter int B_HI = 6
) (
  input  logic clkIn,
  input  logic masterRst,
  input  logic runEnable,
  input  logic selDivA4,
  input  logic selDivB6,
  output logic clkOutA,
  output logic clkOutB
);

  localparam int PERIOD = lcmOf(lcmOf(A_LO, A_HI), lcmOf(B_LO, B_HI));

  divStrobe_t strobe;
  logic       atZero;

  acd_ctrl u_ctrl (
    .clkIn     (clkIn),
    .rstIn     (masterRst),
    .runEnable (runEnable),
    .selDivA4  (selDivA4),
    .selDivB6  (selDivB6),
    .atZero    (atZero),
    .strobe    (strobe)
  );

  acd_path #(
    .A_LO   (A_LO),
    .A_HI   (A_HI),
    .B_LO   (B_LO),
    .B_HI   (B_HI),
    .PERIOD (PERIOD)
  ) u_path (
    .clkIn   (clkIn),
    .rstIn   (masterRst),
    .strobe  (strobe),
    .atZero  (atZero),
    .clkOutA (clkOutA),
    .clkOutB (clkOutB)
  );

endmodule

// File: tb/tb_aligned_clk_divider.sv
`timescale 1ns/1ps
module tb_aligned_clk_divider;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic sA  = 1'b0;
  logic sB  = 1'b0;
  logic clkOutA;
  logic clkOutB;

  always #2 clk = ~clk;

  aligned_clk_divider dut (
    .clkIn     (clk),
    .masterRst (rst),
    .runEnable (en),
    .selDivA4  (sA),
    .selDivB6  (sB),
    .clkOutA   (clkOutA),
    .clkOutB   (clkOutB)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference divider built from the requirements.
  bit mEn;
  bit mRun;
  bit mSA;
  bit mSB;
  bit mA;
  bit mB;
  int mCnt;
  bit frame;
  bit go;
  int ra;
  int rb;

  always @(negedge clk or posedge rst) begin
    if (rst) mEn <= 1'b0;
    else     mEn <= en;
  end

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mCnt <= 0; mRun <= 1'b0; mSA <= 1'b0; mSB <= 1'b0; mA <= 1'b0; mB <= 1'b0;
    end else begin
      frame = (mCnt == 0);
      go = frame ? mEn : mRun;
      ra = (frame ? sA : mSA) ? 4 : 2;
      rb = (frame ? sB : mSB) ? 6 : 4;
      if (frame) begin
        mRun <= mEn; mSA <= sA; mSB <= sB;
      end
      if (go) begin
        mA <= ((mCnt % ra) * 2) < ra;
        mB <= ((mCnt % rb) * 2) < rb;
        mCnt <= (mCnt + 1) % 12;
      end else begin
        mA <= 1'b0; mB <= 1'b0;
      end
    end
  end

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Pulse-width and edge-coincidence tracking.
  bit prevLvl[2];
  bit started[2];
  int runLen[2];
  int halfStart[2];

  task automatic resetTrack();
    for (int c = 0; c < 2; c++) begin
      prevLvl[c] = 1'b0; started[c] = 1'b0; runLen[c] = 0; halfStart[c] = 0;
    end
  endtask

  task automatic step();
    bit lvl;
    int hNow;
    int need;
    bit roseA;
    bit roseB;
    @(posedge clk);
    #3;
    checkBit("R1 clkOutA vs reference", clkOutA, mA);
    checkBit("R2 clkOutB vs reference", clkOutB, mB);
    roseA = clkOutA && !prevLvl[0];
    roseB = clkOutB && !prevLvl[1];
    if (roseB && (((mSB ? 6 : 4) % (mSA ? 4 : 2)) == 0))
      checkBit("R3 A rises with B", roseA, 1'b1);
    for (int c = 0; c < 2; c++) begin
      lvl  = (c == 0) ? clkOutA : clkOutB;
      hNow = (c == 0) ? (mSA ? 2 : 1) : (mSB ? 3 : 2);
      if (!started[c]) begin
        if (lvl != prevLvl[c]) begin
          started[c] = 1'b1; runLen[c] = 1; halfStart[c] = hNow;
        end
      end else if (lvl == prevLvl[c]) begin
        runLen[c]++;
      end else begin
        need = (hNow < halfStart[c]) ? hNow : halfStart[c];
        checks++;
        if (runLen[c] < need) begin
          fails++;
          $display("FAIL R9 channel %0d interval actual=%0d expected>=%0d", c, runLen[c], need);
        end
        runLen[c] = 1; halfStart[c] = hNow;
      end
      prevLvl[c] = lvl;
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // {enable, selA, selB, cycles}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'd24},
    {1'b1, 1'b1, 1'b0, 8'd24},
    {1'b1, 1'b0, 1'b1, 8'd24},
    {1'b1, 1'b1, 1'b1, 8'd30},
    {1'b0, 1'b1, 1'b1, 8'd20},
    {1'b1, 1'b0, 1'b1, 8'd17},
    {1'b1, 1'b1, 1'b0, 8'd13},
    {1'b0, 1'b0, 1'b0, 8'd5},
    {1'b1, 1'b0, 1'b0, 8'd7},
    {1'b1, 1'b1, 1'b1, 8'd19}
  };

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    resetTrack();
    repeat (3) @(posedge clk);
    #3;
    checkBit("R7 reset state clkOutA", clkOutA, 1'b0);
    checkBit("R7 reset state clkOutB", clkOutB, 1'b0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) step();

    // R4: enable high only across a rising edge, never at a falling edge.
    en = 1'b1; #2 en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      checkBit("R4 unsampled pulse A", clkOutA, 1'b0);
      checkBit("R4 unsampled pulse B", clkOutB, 1'b0);
    end

    // R4/R5: enable high only around one falling edge starts a full frame.
    en = 1'b1; #4 en = 1'b0;
    step();
    checkBit("R5 start A high", clkOutA, 1'b1);
    checkBit("R5 start B high", clkOutB, 1'b1);
    repeat (11) step();
    for (int k = 0; k < 3; k++) begin
      step();
      checkBit("R5 stop after frame A", clkOutA, 1'b0);
      checkBit("R5 stop after frame B", clkOutB, 1'b0);
    end

    // Table walk against the reference divider.
    for (int i = 0; i < NV; i++) begin
      en = VEC[i][10]; sA = VEC[i][9]; sB = VEC[i][8];
      repeat (int'(VEC[i][7:0])) step();
    end

    // R6: idle holds low, resume aligned.
    en = 1'b0;
    repeat (14) step();
    for (int k = 0; k < 3; k++) begin
      step();
      checkBit("R6 idle A low", clkOutA, 1'b0);
      checkBit("R6 idle B low", clkOutB, 1'b0);
    end
    en = 1'b1; sA = 1'b1; sB = 1'b1;
    step();
    step();
    checkBit("R6 resume A high", clkOutA, 1'b1);
    checkBit("R6 resume B high", clkOutB, 1'b1);

    // R8: select change mid-frame waits for the frame boundary.
    sA = 1'b0;
    step();
    checkBit("R8 old ratio still in force", clkOutA, 1'b1);
    repeat (11) step();
    checkBit("R8 frame start A high", clkOutA, 1'b1);
    step();
    checkBit("R8 new ratio after boundary", clkOutA, 1'b0);
    repeat (5) step();

    // R7: asynchronous reset mid-run, aligned restart.
    rst = 1'b1;
    resetTrack();
    #0.5;
    checkBit("R7 async clear A", clkOutA, 1'b0);
    checkBit("R7 async clear B", clkOutB, 1'b0);
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    step();
    checkBit("R7 first rise A", clkOutA, 1'b1);
    checkBit("R7 first rise B", clkOutB, 1'b1);
    repeat (24) step();

    report();
  end

endmodule